// File: doc/BRIEF.md
# Byte-Stream CRC7/CRC16 Accumulator

This block keeps a running cyclic redundancy check over the bytes moving through a serial peripheral port. The port's shift logic hands each byte over on an 8-bit bus with a one-cycle valid strobe. There is one bus for the outgoing direction and one for the incoming direction. The accumulator follows one of the two buses, and its current value can always be read on a 16-bit result output. Software uses that value in one of two ways. It can append the checksum to a frame it sends, or it can compare the value against a checksum it has received.

The accumulator runs one of two codes. The short one is a 7-bit code with polynomial x^7 + x^3 + 1. The long one is a 16-bit code with polynomial x^16 + x^12 + x^5 + 1. Both codes start from a seed of zero. Neither code reflects its output or applies a final XOR. The code is picked by a mode input, and the value of that input is captured only when the accumulator is cleared.

To clear the accumulator, drive its clear control low and then high. While the control stays low, the result is held at zero. The value is read once every byte of the chosen stream has been sent. To append the checksum, software first turns the stream select to the incoming side. It then loads the checksum bytes into the outgoing path like ordinary data, and those bytes do not fold into the result.

Top module: `spi_crc_engine`

## Requirements
- R1: When a clear edge captures `poly_sel` = 1, the accumulator runs the 16-bit code: polynomial 0x1021, seed 0, no reflection, no final XOR. After the ASCII bytes "123456789", `crc_value` reads 0x31C3.
- R2: When a clear edge captures `poly_sel` = 0, the accumulator runs the 7-bit code: polynomial 0x09, seed 0. The result sits in `crc_value[6:0]` and `crc_value[15:7]` reads zero. After "123456789", `crc_value` reads 0x0075.
- R3: With `stream_sel` = 0, only strobes on `tx_valid`/`tx_byte` update the value. With `stream_sel` = 1, only strobes on `rx_valid`/`rx_byte` update it. Strobes on the other bus have no effect.
- R4: While `clr_ctl` is 0, `crc_value` reads zero from the following cycle onward, and strobes on either bus are ignored.
- R5: A clear happens in a cycle where `clr_ctl` is 1 after having been 0 in the previous cycle. After that edge `crc_value` is zero, and a byte strobe presented in that same cycle is dropped.
- R6: `poly_sel` is captured only at a clear edge. Changing it partway through a stream leaves the running code unchanged.
- R7: Each strobe of the selected stream folds in one byte, most significant bit first. The new value appears on `crc_value` at the clock edge that samples the strobe. Strobes may arrive in every cycle.
- R8: While `rst_n` is low, `crc_value` is zero and the mode is the 7-bit code. Leaving reset with `clr_ctl` already high does not count as a clear edge.
- R9: Changing `stream_sel` takes effect for the very next strobe. Software can therefore turn the select to the incoming side and send the checksum on the outgoing bus without changing `crc_value`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| poly_sel | input | 1 | Code choice captured at a clear edge: 1 = 16-bit, 0 = 7-bit |
| stream_sel | input | 1 | Tracked bus: 0 = outgoing, 1 = incoming |
| clr_ctl | input | 1 | Clear control: low holds the value at zero, a low-to-high change clears |
| tx_valid | input | 1 | Outgoing byte strobe |
| tx_byte | input | 8 | Outgoing byte |
| rx_valid | input | 1 | Incoming byte strobe |
| rx_byte | input | 8 | Incoming byte |
| crc_value | output | 16 | Current accumulator value, with the 7-bit code zero-extended |

## Verification
The properties take the following for granted about the inputs:
- Each byte strobe is a clean single-cycle level sampled at the rising clock edge.
- `clr_ctl` is a software-written level rather than a glitching pulse.
- Nothing is assumed about the timing between the two buses.

The bench drives every input on the falling clock edge, so each value is settled well before the rising edge that samples it. It changes `poly_sel`, `stream_sel` and `clr_ctl` only between byte strobes or exactly on the cycles under test. It also lets the two buses strobe in the same cycle, so that stream selection is tested with real contention.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;

    localparam int unsigned RESULT_W = 16;

    typedef enum logic {
        MODE_SHORT7 = 1'b0,
        MODE_LONG16 = 1'b1
    } crc_mode_e;

    typedef enum logic {
        SRC_OUTGOING = 1'b0,
        SRC_INCOMING = 1'b1
    } crc_src_e;

    typedef struct packed {
        logic      clr_prev;
        crc_mode_e mode;
    } clr_state_t;

    typedef struct packed {
        logic [RESULT_W-1:0] acc;
    } acc_state_t;

endpackage

// File: rtl/spi_crc_clear_ctl.sv
module spi_crc_clear_ctl
    import spi_crc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr_ctl,
    input  logic      poly_sel,
    output logic      clear_edge,
    output logic      hold_zero,
    output logic      clr_prev_q,
    output crc_mode_e mode_q
);
    clr_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.clr_prev = clr_ctl;
        clear_edge    = clr_ctl && !st_q.clr_prev;
        hold_zero     = !clr_ctl;
        if (clear_edge) begin
            st_d.mode = poly_sel ? MODE_LONG16 : MODE_SHORT7;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.clr_prev <= 1'b1;
            st_q.mode     <= MODE_SHORT7;
        end else begin
            st_q <= st_d;
        end
    end

    assign clr_prev_q = st_q.clr_prev;
    assign mode_q     = st_q.mode;
endmodule

// File: rtl/spi_crc_tap.sv
module spi_crc_tap
    import spi_crc_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              stream_sel,
    input  logic              block,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              take,
    output logic [DATA_W-1:0] data
);
    localparam int unsigned NSRC = 2;

    logic              src_valid [NSRC];
    logic [DATA_W-1:0] src_data  [NSRC];

    assign src_valid[SRC_OUTGOING] = tx_valid;
    assign src_data[SRC_OUTGOING]  = tx_byte;
    assign src_valid[SRC_INCOMING] = rx_valid;
    assign src_data[SRC_INCOMING]  = rx_byte;

    always_comb begin
        take = src_valid[stream_sel] && !block;
        data = src_data[stream_sel];
    end
endmodule

// File: rtl/spi_crc_byte_step.sv
module spi_crc_byte_step #(
    parameter int unsigned          WIDTH  = 16,
    parameter int unsigned          DATA_W = 8,
    parameter logic [WIDTH-1:0]     POLY   = 16'h1021
) (
    input  logic [WIDTH-1:0]  crc_in,
    input  logic [DATA_W-1:0] data,
    output logic [WIDTH-1:0]  crc_out
);
    logic [WIDTH-1:0] chain [DATA_W+1];

    assign chain[0] = crc_in;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic fb;
        assign fb           = chain[i][WIDTH-1] ^ data[DATA_W-1-i];
        assign chain[i+1]   = {chain[i][WIDTH-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc_out = chain[DATA_W];
endmodule

// File: rtl/spi_crc_engine.sv
module spi_crc_engine
    import spi_crc_pkg::*;
#(
    parameter int unsigned  DATA_W      = 8,
    parameter logic [15:0]  LONG_POLY   = 16'h1021,
    parameter logic [6:0]   SHORT_POLY  = 7'h09
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                poly_sel,
    input  logic                stream_sel,
    input  logic                clr_ctl,
    input  logic                tx_valid,
    input  logic [DATA_W-1:0]   tx_byte,
    input  logic                rx_valid,
    input  logic [DATA_W-1:0]   rx_byte,
    output logic [RESULT_W-1:0] crc_value
);
    localparam int unsigned SHORT_W = 7;
    localparam int unsigned LONG_W  = 16;

    logic              clear_edge;
    logic              hold_zero;
    logic              clr_prev_q;
    crc_mode_e         mode_q;
    logic              take;
    logic [DATA_W-1:0] tap_data;
    logic [SHORT_W-1:0] short_next;
    logic [LONG_W-1:0]  long_next;

    acc_state_t st_d, st_q;

    spi_crc_clear_ctl u_clr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_ctl    (clr_ctl),
        .poly_sel   (poly_sel),
        .clear_edge (clear_edge),
        .hold_zero  (hold_zero),
        .clr_prev_q (clr_prev_q),
        .mode_q     (mode_q)
    );

    spi_crc_tap #(.DATA_W(DATA_W)) u_tap (
        .stream_sel (stream_sel),
        .block      (clear_edge | hold_zero),
        .tx_valid   (tx_valid),
        .tx_byte    (tx_byte),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .take       (take),
        .data       (tap_data)
    );

    spi_crc_byte_step #(.WIDTH(SHORT_W), .DATA_W(DATA_W), .POLY(SHORT_POLY)) u_short (
        .crc_in  (st_q.acc[SHORT_W-1:0]),
        .data    (tap_data),
        .crc_out (short_next)
    );

    spi_crc_byte_step #(.WIDTH(LONG_W), .DATA_W(DATA_W), .POLY(LONG_POLY)) u_long (
        .crc_in  (st_q.acc[LONG_W-1:0]),
        .data    (tap_data),
        .crc_out (long_next)
    );

    always_comb begin
        st_d = st_q;
        if (hold_zero || clear_edge) begin
            st_d.acc = '0;
        end else if (take) begin
            if (mode_q == MODE_LONG16) begin
                st_d.acc = long_next;
            end else begin
                st_d.acc = {{(RESULT_W-SHORT_W){1'b0}}, short_next};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.acc <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign crc_value = st_q.acc;
endmodule

// File: rtl/spi_crc_engine_chk.sv
module spi_crc_engine_chk
    import spi_crc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        clr_ctl,
    input logic        clr_prev_q,
    input crc_mode_e   mode_q,
    input logic        stream_sel,
    input logic        tx_valid,
    input logic        rx_valid,
    input logic [15:0] crc_value
);
    logic sel_valid;
    assign sel_valid = stream_sel ? rx_valid : tx_valid;

    // R4
    hold_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_ctl |=> crc_value == 16'h0);

    // R5
    clear_edge_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ctl && !clr_prev_q) |=> crc_value == 16'h0);

    // R2
    short_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == MODE_SHORT7 |-> crc_value[15:7] == 9'h0);

    // R6
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ctl && clr_prev_q) |=> $stable(mode_q));

    // R3
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ctl && clr_prev_q && !sel_valid) |=> $stable(crc_value));
endmodule

bind spi_crc_engine spi_crc_engine_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_ctl    (clr_ctl),
    .clr_prev_q (clr_prev_q),
    .mode_q     (mode_q),
    .stream_sel (stream_sel),
    .tx_valid   (tx_valid),
    .rx_valid   (rx_valid),
    .crc_value  (crc_value)
);

// File: tb/spi_crc_engine_test.sv
module spi_crc_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        poly_sel = 1'b1;
    logic        stream_sel = 1'b0;
    logic        clr_ctl = 1'b1;
    logic        tx_valid = 1'b0;
    logic [7:0]  tx_byte = 8'h0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h0;
    logic [15:0] crc_value;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    spi_crc_engine uut (
        .clk(clk), .rst_n(rst_n), .poly_sel(poly_sel), .stream_sel(stream_sel),
        .clr_ctl(clr_ctl), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .crc_value(crc_value)
    );

    function automatic logic [15:0] ref16(input logic [15:0] c, input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            logic fb;
            fb = c[15] ^ b[i];
            c = {c[14:0], 1'b0};
            if (fb) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    function automatic logic [15:0] ref7(input logic [15:0] c, input logic [7:0] b);
        logic [6:0] r;
        r = c[6:0];
        for (int i = 7; i >= 0; i--) begin
            logic fb;
            fb = r[6] ^ b[i];
            r = {r[5:0], 1'b0};
            if (fb) r = r ^ 7'h09;
        end
        return {9'h0, r};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic cycle(input logic tv, input logic [7:0] tb_, input logic rv, input logic [7:0] rb);
        tx_valid = tv; tx_byte = tb_; rx_valid = rv; rx_byte = rb;
        @(negedge clk);
        tx_valid = 1'b0; rx_valid = 1'b0;
    endtask

    task automatic do_clear(input logic mode);
        poly_sel = mode;
        clr_ctl = 1'b0;
        @(negedge clk);
        clr_ctl = 1'b1;
        @(negedge clk);
    endtask

    function automatic logic [7:0] digit(input int k);
        return 8'h31 + 8'(k);
    endfunction

    task automatic t_reset();
        check("R8 reset value", crc_value, 16'h0);
        cycle(1'b1, 8'h31, 1'b0, 8'h0);
        check("R8 mode is 7-bit after reset", crc_value, ref7(16'h0, 8'h31));
    endtask

    task automatic t_long();
        logic [15:0] m = 16'h0;
        stream_sel = 1'b0;
        do_clear(1'b1);
        check("R5 zero after clear", crc_value, 16'h0);
        for (int k = 0; k < 9; k++) begin
            cycle(1'b1, digit(k), 1'b0, 8'h0);
            m = ref16(m, digit(k));
            check("R7 per-byte 16-bit", crc_value, m);
        end
        check("R1 check value", crc_value, 16'h31C3);
    endtask

    task automatic t_short();
        do_clear(1'b0);
        for (int k = 0; k < 9; k++) cycle(1'b1, digit(k), 1'b0, 8'h0);
        check("R2 check value", crc_value, 16'h0075);
    endtask

    task automatic t_incoming();
        logic [15:0] m = 16'h0;
        stream_sel = 1'b1;
        do_clear(1'b1);
        for (int k = 0; k < 6; k++) begin
            cycle(1'b1, 8'hA5 ^ 8'(k), 1'b1, 8'(k * 37 + 3));
            m = ref16(m, 8'(k * 37 + 3));
        end
        cycle(1'b1, 8'h77, 1'b0, 8'h0);
        check("R3 incoming only", crc_value, m);
        stream_sel = 1'b0;
    endtask

    task automatic t_hold();
        do_clear(1'b1);
        cycle(1'b1, 8'h5A, 1'b0, 8'h0);
        clr_ctl = 1'b0;
        cycle(1'b1, 8'h11, 1'b1, 8'h22);
        cycle(1'b1, 8'h33, 1'b0, 8'h0);
        check("R4 held at zero", crc_value, 16'h0);
        clr_ctl = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_edge_drop();
        clr_ctl = 1'b0;
        poly_sel = 1'b1;
        @(negedge clk);
        clr_ctl = 1'b1;
        cycle(1'b1, 8'hC3, 1'b0, 8'h0);
        check("R5 strobe on clear dropped", crc_value, 16'h0);
        cycle(1'b1, 8'h3C, 1'b0, 8'h0);
        check("R5 first byte after clear", crc_value, ref16(16'h0, 8'h3C));
    endtask

    task automatic t_mode_change();
        logic [15:0] m = 16'h0;
        do_clear(1'b1);
        cycle(1'b1, 8'h10, 1'b0, 8'h0); m = ref16(m, 8'h10);
        poly_sel = 1'b0;
        cycle(1'b1, 8'hF0, 1'b0, 8'h0); m = ref16(m, 8'hF0);
        cycle(1'b1, 8'h0F, 1'b0, 8'h0); m = ref16(m, 8'h0F);
        check("R6 mode held mid-stream", crc_value, m);
    endtask

    task automatic t_append();
        logic [15:0] m = 16'h0;
        stream_sel = 1'b0;
        do_clear(1'b1);
        for (int k = 0; k < 4; k++) begin
            cycle(1'b1, 8'(8'h80 + k), 1'b0, 8'h0);
            m = ref16(m, 8'(8'h80 + k));
        end
        stream_sel = 1'b1;
        cycle(1'b1, m[15:8], 1'b0, 8'h0);
        cycle(1'b1, m[7:0], 1'b0, 8'h0);
        check("R9 append leaves value", crc_value, m);
        stream_sel = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        poly_sel = 1'b0;
        @(negedge clk);
        t_reset();
        t_long();
        t_short();
        t_incoming();
        t_hold();
        t_edge_drop();
        t_mode_change();
        t_append();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule